// File: doc/BRIEF.md
# Segmented Thermometer Switch Decoder

This block turns a binary code into the switch controls of a segmented current-steering converter. The code is captured in an input register and cut into three fields. The upper field is expanded into a thermometer group of unit cells that each carry the largest weight. The middle field is expanded into a second thermometer group with a smaller weight. The lowest field passes on unchanged to binary-weighted cells.

Every control line is then captured in one wide output register, so all switches change on the same clock edge. Because the upper groups are thermometer coded, a larger code never switches off a cell that a smaller code had on. This keeps the transfer monotonic whatever the mismatch between the cells.

The default configuration is a 14-bit code, a 5-bit upper field (31 cells of weight 512), a 4-bit middle field (15 cells of weight 32) and a 5-bit binary tail. That makes 51 control lines.

Top module: `seg_dac_front`

## Requirements
- R1: The switch controls for a code appear on the second rising clock edge after the code is presented. After the first edge the previous controls are still held. All control lines change only on a rising edge.
- R2: Output bits [50:20] form the upper thermometer group. Bit 20+k is 1 exactly when code[13:9] is greater than k, for k = 0 to 30.
- R3: Output bits [19:5] form the middle thermometer group. Bit 5+k is 1 exactly when code[8:5] is greater than k, for k = 0 to 14.
- R4: Output bits [4:0] equal code[4:0], the binary tail. Bit 0 carries weight 1.
- R5: The sum 512 × (ones in bits [50:20]) + 32 × (ones in bits [19:5]) + bits [4:0] equals the code. At code 16383 all 51 bits are 1.
- R6: When the code rises from one sample to the next, no bit of the upper group that was 1 becomes 0.
- R7: A synchronous active-high reset clears both the input register and the output register. The output is all zeros after the first edge with reset high. It stays zero for one further edge after reset is released, even when a nonzero code is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_i | input | 14 | Binary code to convert |
| sw_o | output | 51 | Registered switch controls: upper group, middle group, binary tail |

## Verification
Each code reaches the switch controls two rising edges after it is applied. The bench drives inputs on falling edges and compares the output on the falling edge that follows the second rising edge. In the streaming test it compares against the code applied two falling edges earlier. The latency check also samples after only one edge to confirm that the old controls are still held. Reset is checked one edge after assertion and one edge after release, which is where the two cleared registers show.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int CODE_W = 14,
  parameter int HI_W   = 5,
  parameter int MID_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_W-1:0]     code_i,
  output logic [(2**HI_W-1)+(2**MID_W-1)+(CODE_W-HI_W-MID_W)-1:0] sw_o
);
  localparam int LO_W  = CODE_W - HI_W - MID_W;
  localparam int HI_N  = 2**HI_W - 1;
  localparam int MID_N = 2**MID_W - 1;
  localparam int SW_W  = HI_N + MID_N + LO_W;

  logic [CODE_W-1:0] code_q;
  logic [SW_W-1:0]   sw_q;
  logic [HI_N-1:0]   hi_t;
  logic [MID_N-1:0]  mid_t;

  wire [HI_W-1:0]  hi_v  = code_q[CODE_W-1 -: HI_W];
  wire [MID_W-1:0] mid_v = code_q[LO_W +: MID_W];
  wire [LO_W-1:0]  lo_v  = code_q[LO_W-1:0];

  for (genvar k = 0; k < HI_N; k++) begin : g_hi
    assign hi_t[k] = hi_v > HI_W'(k);
  end

  for (genvar k = 0; k < MID_N; k++) begin : g_mid
    assign mid_t[k] = mid_v > MID_W'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sw_q   <= '0;
    end else begin
      code_q <= code_i;
      sw_q   <= {hi_t, mid_t, lo_v};
    end
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
  parameter int CODE_W = 14,
  parameter int HI_W   = 5,
  parameter int MID_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_i,
  input logic [(2**HI_W-1)+(2**MID_W-1)+(CODE_W-HI_W-MID_W)-1:0] sw_o
);
  localparam int LO_W  = CODE_W - HI_W - MID_W;
  localparam int HI_N  = 2**HI_W - 1;
  localparam int MID_N = 2**MID_W - 1;

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  wire [HI_N-1:0]  hi_g  = sw_o[LO_W+MID_N +: HI_N];
  wire [MID_N-1:0] mid_g = sw_o[LO_W +: MID_N];
  wire [LO_W-1:0]  lo_g  = sw_o[LO_W-1:0];

  wire [31:0] wsum = ($countones(hi_g) << (CODE_W-HI_W)) +
                     ($countones(mid_g) << LO_W) + 32'(lo_g);

  p_weighted_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (wsum == 32'($past(code_i, 2))));

  p_hi_therm_r2: assert property (@(posedge clk) disable iff (rst)
    (hi_g & (hi_g + 1'b1)) == '0);

  p_mid_therm_r3: assert property (@(posedge clk) disable iff (rst)
    (mid_g & (mid_g + 1'b1)) == '0);

  p_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(code_i, 2) >= $past(code_i, 3)) |->
      (($past(hi_g) & ~hi_g) == '0));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (sw_o == '0));
endmodule

bind seg_dac_front seg_dac_front_chk #(
  .CODE_W(CODE_W), .HI_W(HI_W), .MID_W(MID_W)
) u_chk (
  .clk(clk), .rst(rst), .code_i(code_i), .sw_o(sw_o)
);

// File: tb/seg_dac_front_bench.sv
module seg_dac_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] code = '0;
  logic [50:0] sw;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_dac_front u_seg_dac_front (.clk(clk), .rst(rst), .code_i(code), .sw_o(sw));

  localparam int NV = 13;
  localparam logic [13:0] VC [NV] = '{14'd0, 14'd1, 14'd31, 14'd32, 14'd511, 14'd512,
    14'd1000, 14'd5000, 14'd8191, 14'd8192, 14'd12345, 14'd16352, 14'd16383};
  localparam int VH [NV] = '{0, 0, 0, 0, 0, 1, 1, 9, 15, 16, 24, 31, 31};
  localparam int VM [NV] = '{0, 0, 0, 1, 15, 0, 15, 12, 15, 0, 1, 15, 15};

  function automatic logic [50:0] build(int h, int m, logic [4:0] lo);
    logic [50:0] r = '0;
    for (int k = 0; k < 31; k++) r[20+k] = (k < h);
    for (int k = 0; k < 15; k++) r[5+k]  = (k < m);
    r[4:0] = lo;
    return r;
  endfunction

  function automatic logic [50:0] expect_of(logic [13:0] c);
    return build(int'(c[13:9]), int'(c[8:5]), c[4:0]);
  endfunction

  function automatic int wsum(logic [50:0] s);
    return 512 * $countones(s[50:20]) + 32 * $countones(s[19:5]) + int'(s[4:0]);
  endfunction

  task automatic chk(string req, logic [50:0] act, logic [50:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] hist [20];
    @(negedge clk); @(negedge clk);
    chk("R7 reset state", sw, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      code = VC[i];
      settle();
      chk("R2 R3 R4 table", sw, build(VH[i], VM[i], VC[i][4:0]));
      chk_int("R5 weighted sum", wsum(sw), int'(VC[i]));
    end
    chk("R5 full scale", sw, {51{1'b1}});

    code = 14'd600;
    settle();
    code = 14'd9000;
    @(posedge clk); @(negedge clk);
    chk("R1 old value after one edge", sw, expect_of(14'd600));
    @(posedge clk); @(negedge clk);
    chk("R1 new value after two edges", sw, expect_of(14'd9000));

    for (int i = 0; i < 20; i++) begin
      if (i >= 2) begin
        chk("R1 streaming", sw, expect_of(hist[i-2]));
        if (i >= 3) begin
          checks++;
          if ((expect_of(hist[i-3]) & ~sw) & {31'h7fffffff, 20'h0}) begin
            errors++;
            $display("FAIL R6 monotonic: actual=%h expected no cleared upper cell", sw);
          end
        end
      end
      hist[i] = 14'(i * 851 + 3);
      code = hist[i];
      @(negedge clk);
    end

    code = 14'd16383;
    settle();
    rst = 1'b1;
    @(negedge clk);
    chk("R7 clear after assert", sw, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 zero one edge after release", sw, '0);
    @(negedge clk);
    chk("R7 recover after release", sw, expect_of(14'd16383));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule